// File: doc/BRIEF.md
# Continuous ADC Conversion Sequencer

This block sits on a byte-wide register bus and drives an 8-bit converter through repeated conversions. Software writes one control register to pick a channel, enable the converter and choose the conversion clock. Every such write restarts the conversion counter. From then on the same channel is converted again every 32 conversion-clock ticks, and each new result overwrites the previous one. A completion flag in the control register is raised with each result. The flag is dropped when the control register is written or when the result register is read.

The converter core is modelled by one digital input byte per source. There are 16 external sources and 4 internal reference sources. The conversion clock is either the bus clock itself or a slower, asynchronous RC clock. The RC clock passes through a synchroniser, and each rising edge becomes a one-cycle tick in the bus domain. As a result, every result update lands on a bus-clock edge, at most one per cycle. A stop input halts the RC ticks without touching the enable bit. In bus-clock mode the stop input has no effect, so conversions keep running while the processor idles.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the control register (address 0x1E) reads 0x00 and the result register (address 0x1F) reads 0x00.
- R2: The control register reads as {flag, clock select, enable, channel[4:0]}, with bit 7 the completion flag, bit 6 the RC clock select, bit 5 the enable and bits 4:0 the channel. Bit 7 of written data is ignored.
- R3: Any write to the control register clears the flag and restarts the tick counter. With enable set, the first result arrives on the 32nd conversion tick after the write. The tick on the write edge itself does not count.
- R4: With enable set, a result is taken every 32 ticks. Each result overwrites the result register and sets the flag, whatever the flag held before.
- R5: A bus read of the result register clears the flag, unless a result completes on the same edge, in which case the flag is set.
- R6: While enable is 0, no conversion completes, the flag stays 0 and the result register keeps its value.
- R7: Channel codes 0–15 select the external inputs. Codes 16–19 select the reference inputs 0–3. Codes 20–31 give a result of 0x00.
- R8: With bit 6 set, a conversion tick is a rising edge of the RC clock, seen after a two-stage synchroniser and one edge-detect register, so there is at most one tick per bus cycle.
- R9: The stop input, while high in RC mode, freezes the tick counter. Enable and the other control bits keep their values, and counting resumes after stop is released. In bus-clock mode stop has no effect.
- R10: Reads of any address other than 0x1E and 0x1F return 0x00. Writes to 0x1F are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rc_clk | input | 1 | Asynchronous RC conversion clock |
| stop_mode | input | 1 | Stop request; halts RC ticks |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe, used for the read side effect on the result register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| ext_in | input | 128 | Sixteen external source bytes, source n at bits 8n+7:8n |
| ref_in | input | 32 | Four reference source bytes, source n at bits 8n+7:8n |

## Verification
The assertions assume that a bus write and a bus read of the result register are never presented in the same cycle. They also assume the RC clock stays low or high for at least one full bus cycle, so the synchroniser sees every level. The stimulus drives every bus strobe from a single sequence that issues one access per cycle. It toggles the RC clock only every third bus cycle, one nanosecond after the bus edge. The source bytes and the stop input change only in that same post-edge window, so every value the design samples is stable.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DATA_W = 8;
    localparam int CH_W   = 5;

    // bit positions of the control register as software sees it
    localparam int BIT_FLAG = 7;
    localparam int BIT_RC   = 6;
    localparam int BIT_EN   = 5;

    typedef struct packed {
        logic              coco;
        logic              adrc;
        logic              adon;
        logic [CH_W-1:0]   ch;
        logic [DATA_W-1:0] data;
    } ctrl_regs_t;

endpackage

// File: rtl/adc_rc_sync.sv
module adc_rc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rc_clk,
    output logic tick_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], rc_clk};
        s_d.last  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_o = s_q.chain[STAGES-1] & ~s_q.last;

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int CONV_LEN = 32,
    localparam int CNT_W   = $clog2(CONV_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    output logic             done,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_LEN - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = run && !restart && (cnt_q == LAST);
    assign cnt  = cnt_q;

endmodule

// File: rtl/adc_chan_mux.sv
module adc_chan_mux #(
    parameter int N_EXT  = 16,
    parameter int N_REF  = 4,
    parameter int DATA_W = 8,
    parameter int CH_W   = 5
) (
    input  logic [CH_W-1:0]         sel,
    input  logic [N_EXT*DATA_W-1:0] ext_in,
    input  logic [N_REF*DATA_W-1:0] ref_in,
    output logic [DATA_W-1:0]       sample
);

    localparam int N_SRC = N_EXT + N_REF;

    logic [DATA_W-1:0] src [N_SRC];

    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        assign src[g] = ext_in[g*DATA_W +: DATA_W];
    end

    for (genvar g = 0; g < N_REF; g++) begin : g_ref
        assign src[N_EXT+g] = ref_in[g*DATA_W +: DATA_W];
    end

    // codes beyond the last source fall through to zero
    always_comb begin
        sample = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel == CH_W'(i)) begin
                sample = src[i];
            end
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h1E,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 8'h1F,
    parameter int                N_EXT       = 16,
    parameter int                N_REF       = 4,
    parameter int                CONV_LEN    = 32,
    parameter int                SYNC_STAGES = 2,
    localparam int               CNT_W       = $clog2(CONV_LEN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rc_clk,
    input  logic                     stop_mode,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [N_EXT*DATA_W-1:0]  ext_in,
    input  logic [N_REF*DATA_W-1:0]  ref_in
);

    ctrl_regs_t regs_d, regs_q;

    logic              wr_ctrl;
    logic              rd_data;
    logic              rc_tick;
    logic              tick_en;
    logic              conv_run;
    logic              conv_done;
    logic [CNT_W-1:0]  conv_cnt;
    logic [DATA_W-1:0] sel_sample;
    logic              unused_wflag;

    assign wr_ctrl      = bus_wr && (bus_addr == CTRL_ADDR);
    assign rd_data      = bus_rd && (bus_addr == DATA_ADDR);
    assign unused_wflag = bus_wdata[BIT_FLAG];

    adc_rc_sync #(
        .STAGES (SYNC_STAGES)
    ) i_rc_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rc_clk (rc_clk),
        .tick_o (rc_tick)
    );

    // bus-clock mode ticks every cycle; RC mode uses synchronised edges
    assign tick_en  = regs_q.adrc ? (rc_tick && !stop_mode) : 1'b1;
    assign conv_run = regs_q.adon && tick_en;

    adc_conv_timer #(
        .CONV_LEN (CONV_LEN)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_ctrl),
        .run     (conv_run),
        .done    (conv_done),
        .cnt     (conv_cnt)
    );

    adc_chan_mux #(
        .N_EXT  (N_EXT),
        .N_REF  (N_REF),
        .DATA_W (DATA_W),
        .CH_W   (CH_W)
    ) i_mux (
        .sel    (regs_q.ch),
        .ext_in (ext_in),
        .ref_in (ref_in),
        .sample (sel_sample)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_ctrl) begin
            regs_d.adrc = bus_wdata[BIT_RC];
            regs_d.adon = bus_wdata[BIT_EN];
            regs_d.ch   = bus_wdata[CH_W-1:0];
            regs_d.coco = 1'b0;
        end else if (conv_done) begin
            regs_d.data = sel_sample;
            regs_d.coco = 1'b1;
        end else if (rd_data) begin
            regs_d.coco = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata[BIT_FLAG]   = regs_q.coco;
            bus_rdata[BIT_RC]     = regs_q.adrc;
            bus_rdata[BIT_EN]     = regs_q.adon;
            bus_rdata[CH_W-1:0]   = regs_q.ch;
        end else if (bus_addr == DATA_ADDR) begin
            bus_rdata = regs_q.data;
        end
    end

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_ctrl,
    input logic              rd_data,
    input logic              stop_mode,
    input logic              rc_tick,
    input logic              conv_done,
    input logic [CNT_W-1:0]  conv_cnt,
    input logic [DATA_W-1:0] sel_sample,
    input ctrl_regs_t        regs
);

    AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> !regs.coco);                                            // R3

    AST_RESULT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && !wr_ctrl |=> regs.coco && (regs.data == $past(sel_sample))); // R4

    AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data && !conv_done && !wr_ctrl |=> !regs.coco);                  // R5

    AST_DISABLED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !regs.adon |-> !regs.coco);                                         // R6

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(regs.data));                                 // R6

    AST_RC_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rc_tick |=> !rc_tick);                                              // R8

    AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        regs.adrc && stop_mode && !wr_ctrl |=> $stable(conv_cnt) && $stable(regs.adon)); // R9

endmodule

bind adc_seq_ctrl adc_seq_chk #(
    .CNT_W (CNT_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .rd_data    (rd_data),
    .stop_mode  (stop_mode),
    .rc_tick    (rc_tick),
    .conv_done  (conv_done),
    .conv_cnt   (conv_cnt),
    .sel_sample (sel_sample),
    .regs       (regs_q)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;

    localparam logic [7:0] CTRL_A = 8'h1E;
    localparam logic [7:0] DATA_A = 8'h1F;
    localparam int         CONV   = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rc_clk = 1'b0;
    logic         stop_mode = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic [127:0] ext_in;
    logic [31:0]  ref_in = {8'hD3, 8'hC2, 8'hB1, 8'hA0};

    always #2 clk = ~clk;   // 250 MHz

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rc_clk    (rc_clk),
        .stop_mode (stop_mode),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_in    (ext_in),
        .ref_in    (ref_in)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference model ----------------
    logic       m_flag, m_rc, m_en;
    logic [4:0] m_ch;
    logic [7:0] m_data;
    int         m_cnt;
    logic [2:0] rc_hist;   // rc_hist[2] oldest synchronised sample
    logic       m_tick, m_adv;

    function automatic logic [7:0] source_of(input logic [4:0] ch);
        if (ch < 16)      return ext_in[ch*8 +: 8];
        else if (ch < 20) return ref_in[(ch-16)*8 +: 8];
        else              return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = 0; m_rc = 0; m_en = 0; m_ch = 0; m_data = 0;
            m_cnt = 0; rc_hist = 0;
        end else begin
            m_tick  = rc_hist[1] && !rc_hist[2];
            rc_hist = {rc_hist[1:0], rc_clk};
            m_adv   = m_en && (m_rc ? (m_tick && !stop_mode) : 1'b1);
            if (bus_wr && bus_addr == CTRL_A) begin
                m_rc = bus_wdata[6]; m_en = bus_wdata[5]; m_ch = bus_wdata[4:0];
                m_flag = 0; m_cnt = 0;
            end else if (m_adv && m_cnt == CONV-1) begin
                m_data = source_of(m_ch); m_flag = 1; m_cnt = 0;
            end else begin
                if (m_adv) m_cnt++;
                if (bus_rd && bus_addr == DATA_A) m_flag = 0;
            end
        end
    end

    function automatic logic [7:0] expect_rd(input logic [7:0] a);
        if (a == CTRL_A)      return {m_flag, m_rc, m_en, m_ch};
        else if (a == DATA_A) return m_data;
        else                  return 8'h00;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h t=%0t", req, bus_addr, act, exp, $time);
        end
    endtask

    task automatic step(input logic [7:0] a, input logic wr, input logic rd, input logic [7:0] wd);
        @(posedge clk);
        #1;
        bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
        #1;
        check(cur_req, bus_rdata, expect_rd(a));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step((i % 2) ? DATA_A : CTRL_A, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        step(CTRL_A, 1'b1, 1'b0, v);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // RC clock: six bus cycles per period, edges just after a bus edge
    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 rc_clk = ~rc_clk;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) ext_in[i*8 +: 8] = 8'(8'h10 + i * 7);
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        cur_req = "R1";
        step(CTRL_A, 0, 0, 0);
        check("R1", bus_rdata, 8'h00);
        step(DATA_A, 0, 0, 0);
        check("R1", bus_rdata, 8'h00);

        cur_req = "R2";   // flag bit in written data must be ignored
        write_ctrl(8'hA5);
        step(CTRL_A, 0, 0, 0);
        check("R2", bus_rdata, 8'h25);

        cur_req = "R4";
        idle(40);
        ext_in[5*8 +: 8] = 8'h5A;
        idle(70);

        cur_req = "R3";   // restart mid conversion
        idle(9);
        write_ctrl(8'h25);
        idle(40);

        cur_req = "R5";   // read clears, and same-edge completion wins
        step(DATA_A, 0, 1, 0);
        step(CTRL_A, 0, 0, 0);
        write_ctrl(8'h25);
        idle(31);
        step(DATA_A, 0, 1, 0);
        step(CTRL_A, 0, 0, 0);
        check("R5", bus_rdata, 8'hA5);
        idle(5);
        step(DATA_A, 0, 1, 0);
        step(CTRL_A, 0, 0, 0);
        check("R5", bus_rdata, 8'h25);

        cur_req = "R7";
        write_ctrl(8'h31); idle(36);
        step(DATA_A, 0, 0, 0); check("R7", bus_rdata, 8'hB1);
        write_ctrl(8'h33); idle(36);
        step(DATA_A, 0, 0, 0); check("R7", bus_rdata, 8'hD3);
        write_ctrl(8'h36); idle(36);
        step(DATA_A, 0, 0, 0); check("R7", bus_rdata, 8'h00);
        write_ctrl(8'h2F); idle(36);
        step(DATA_A, 0, 0, 0); check("R7", bus_rdata, 8'h79);

        cur_req = "R6";
        write_ctrl(8'h05);
        idle(80);
        step(DATA_A, 0, 0, 0); check("R6", bus_rdata, 8'h79);

        cur_req = "R10";
        step(8'h00, 0, 1, 0); check("R10", bus_rdata, 8'h00);
        step(DATA_A, 1, 0, 8'h77);
        step(8'h40, 0, 0, 0); check("R10", bus_rdata, 8'h00);
        step(DATA_A, 0, 0, 0); check("R10", bus_rdata, 8'h79);

        cur_req = "R8";
        write_ctrl(8'h62);
        idle(420);

        cur_req = "R9";
        idle(50);
        stop_mode = 1'b1;
        idle(150);
        step(CTRL_A, 0, 0, 0); check("R9", bus_rdata[5:0], 6'h22);
        stop_mode = 1'b0;
        idle(250);
        write_ctrl(8'h22);   // bus-clock mode: stop must not matter
        stop_mode = 1'b1;
        idle(70);
        stop_mode = 1'b0;
        idle(10);

        finish_run();
    end

endmodule